// File: doc/BRIEF.md
# Operand Hazard Resolver for an In-Order Integer Pipeline

This combinational block sits beside the decode stage of a five-stage in-order integer pipeline. Each cycle it takes the two source register numbers of the instruction in decode, along with the decoder's flags that say whether each source is really read. It compares them against the destination of the instruction in execute and the destination of the instruction in the memory stage. From that comparison it produces a bypass select and a bypass value for each source operand, and one stall request for the front of the pipe.

A mode input picks between two policies. In interlock-only mode, any dependency stalls decode, and nothing is bypassed. In bypass mode, a result held in the memory stage, or an ALU result in execute, is steered straight to the operand that needs it. A stall is raised only when the execute-stage producer is a load, because its data does not exist yet.

A producer with write disabled never creates a dependency, and neither does one that targets register zero. An instruction that does not read a field never depends on it, so an unused second-source field cannot stall the pipe. The writeback stage needs no check, because the register file forwards a same-cycle write to the decode read port.

Top module: `hazard_unit`

## Requirements
- R1: A producer stage is considered only when its write enable is 1 and its destination register number is not zero; otherwise it causes neither a stall nor a bypass.
- R2: The first source is compared only when its use flag is 1; with the flag at 0 its select is 00 and its value 0, whatever the producers hold.
- R3: The second source is compared only when its use flag is 1; with the flag at 0 its select is 00 and its value 0, whatever the producers hold.
- R4: In bypass mode, an operand that matches only the memory-stage producer gets select 01 and the memory-stage write value.
- R5: In bypass mode, an operand that matches a non-load execute-stage producer gets select 10 and the execute-stage ALU result.
- R6: When an operand matches both producers, the execute-stage producer wins over the memory-stage producer.
- R7: In bypass mode, an operand that matches an execute-stage load raises stall, and that operand's select is 00.
- R8: In interlock-only mode (mode input 0), any match on a used operand raises stall, and both selects are 00.
- R9: In bypass mode, stall is 0 unless R7 applies.
- R10: An operand with no match has select 00 and bypass value 0. The select codes are 00 for none, 01 for the memory stage and 10 for the execute stage; 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_fwd | input | 1 | 1 = bypass mode, 0 = interlock-only mode |
| dec_src_a | input | REG_AW | First source register number of the decode instruction |
| dec_src_b | input | REG_AW | Second source register number of the decode instruction |
| dec_use_a | input | 1 | Decode instruction reads the first source |
| dec_use_b | input | 1 | Decode instruction reads the second source |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_dst | input | REG_AW | Execute-stage destination register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_alu_val | input | DATA_W | Execute-stage ALU result |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_AW | Memory-stage destination register |
| mem_wr_val | input | DATA_W | Value the memory-stage instruction will write |
| src_a_sel | output | 2 | Bypass select for the first source |
| src_a_val | output | DATA_W | Bypass value for the first source |
| src_b_sel | output | 2 | Bypass select for the second source |
| src_b_val | output | DATA_W | Bypass value for the second source |
| stall | output | 1 | Hold decode and insert a bubble |

## Verification
The bench sweeps every combination of flags, enables and mode with register numbers drawn from zero to three. This covers register zero as source and destination, both producers matching the same operand, and both operands matching the same producer. A design that compared an unused field would stall or bypass when the use flag is 0. A design that let register zero match would bypass a value for an instruction that reads the hard-wired zero. A design that gave the older stage priority would hand over a stale value when both producers target the same register. A design that bypassed from an execute-stage load would deliver an ALU address instead of the loaded data, and the missing stall shows at the port.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    typedef enum logic [1:0] {
        FWD_NONE = 2'b00,
        FWD_MEM  = 2'b01,
        FWD_EXE  = 2'b10
    } fwd_sel_e;

    localparam int unsigned NUM_SRC = 2;

    // A producer writes a live register that the consumer actually reads
    function automatic logic dep_match(
        input logic        use_src,
        input logic        wr_en,
        input logic [15:0] src,
        input logic [15:0] dst
    );
        return use_src && wr_en && (dst != '0) && (dst == src);
    endfunction

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int unsigned REG_AW = 5
) (
    input  logic              use_src,
    input  logic [REG_AW-1:0] src,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] dst,
    output logic              hit
);
    import hazard_pkg::*;

    localparam int unsigned PAD = 16 - REG_AW;

    always_comb begin
        hit = dep_match(use_src, wr_en, {{PAD{1'b0}}, src}, {{PAD{1'b0}}, dst});
    end

    always_comb begin
        if (!$isunknown({use_src, wr_en, dst})) begin
            AST_ZERO_DST_NO_HIT: assert (!(dst == '0 && hit)); // R1
            AST_UNUSED_NO_HIT:   assert (use_src || !hit);     // R2
        end
    end
endmodule

// File: rtl/hz_operand.sv
module hz_operand #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              mode_fwd,
    input  logic              use_src,
    input  logic [REG_AW-1:0] src,
    input  logic              ex_wr_en,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_is_load,
    input  logic [DATA_W-1:0] ex_val,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic [DATA_W-1:0] mem_val,
    output hazard_pkg::fwd_sel_e sel,
    output logic [DATA_W-1:0] val,
    output logic              any_hit,
    output logic              load_block
);
    import hazard_pkg::*;

    logic ex_hit;
    logic mem_hit;

    hz_match #(.REG_AW(REG_AW)) u_ex_cmp (
        .use_src(use_src), .src(src), .wr_en(ex_wr_en), .dst(ex_dst), .hit(ex_hit)
    );

    hz_match #(.REG_AW(REG_AW)) u_mem_cmp (
        .use_src(use_src), .src(src), .wr_en(mem_wr_en), .dst(mem_dst), .hit(mem_hit)
    );

    always_comb begin
        any_hit    = ex_hit || mem_hit;
        load_block = ex_hit && ex_is_load;
        sel        = FWD_NONE;
        val        = '0;
        if (mode_fwd) begin
            if (ex_hit) begin
                // younger producer wins; a load has no data yet
                if (!ex_is_load) begin
                    sel = FWD_EXE;
                    val = ex_val;
                end
            end else if (mem_hit) begin
                sel = FWD_MEM;
                val = mem_val;
            end
        end
    end

    always_comb begin
        if (!$isunknown({mode_fwd, use_src, ex_wr_en, ex_is_load, mem_wr_en, sel})) begin
            AST_EXE_BEATS_MEM: assert (!(ex_hit && sel == FWD_MEM));             // R6
            AST_NO_LOAD_BYPASS: assert (!(ex_is_load && sel == FWD_EXE));        // R7
            AST_MEM_VALUE:      assert (sel != FWD_MEM || val == mem_val);       // R4
            AST_EXE_VALUE:      assert (sel != FWD_EXE || val == ex_val);        // R5
            AST_IDLE_ZERO:      assert (sel != FWD_NONE || val == '0);           // R10
        end
    end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              mode_fwd,
    input  logic [REG_AW-1:0] dec_src_a,
    input  logic [REG_AW-1:0] dec_src_b,
    input  logic              dec_use_a,
    input  logic              dec_use_b,
    input  logic              ex_wr_en,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_is_load,
    input  logic [DATA_W-1:0] ex_alu_val,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic [DATA_W-1:0] mem_wr_val,
    output logic [1:0]        src_a_sel,
    output logic [DATA_W-1:0] src_a_val,
    output logic [1:0]        src_b_sel,
    output logic [DATA_W-1:0] src_b_val,
    output logic              stall
);
    import hazard_pkg::*;

    logic [REG_AW-1:0] src_num [NUM_SRC];
    logic              src_use [NUM_SRC];
    fwd_sel_e          op_sel  [NUM_SRC];
    logic [DATA_W-1:0] op_val  [NUM_SRC];
    logic [NUM_SRC-1:0] op_hit;
    logic [NUM_SRC-1:0] op_block;

    always_comb begin
        src_num[0] = dec_src_a;
        src_num[1] = dec_src_b;
        src_use[0] = dec_use_a;
        src_use[1] = dec_use_b;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
        hz_operand #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_op (
            .mode_fwd  (mode_fwd),
            .use_src   (src_use[g]),
            .src       (src_num[g]),
            .ex_wr_en  (ex_wr_en),
            .ex_dst    (ex_dst),
            .ex_is_load(ex_is_load),
            .ex_val    (ex_alu_val),
            .mem_wr_en (mem_wr_en),
            .mem_dst   (mem_dst),
            .mem_val   (mem_wr_val),
            .sel       (op_sel[g]),
            .val       (op_val[g]),
            .any_hit   (op_hit[g]),
            .load_block(op_block[g])
        );
    end

    always_comb begin
        src_a_sel = op_sel[0];
        src_a_val = op_val[0];
        src_b_sel = op_sel[1];
        src_b_val = op_val[1];
        stall     = mode_fwd ? (|op_block) : (|op_hit);
    end

    always_comb begin
        if (!$isunknown({mode_fwd, dec_use_a, dec_use_b, ex_wr_en, ex_is_load, mem_wr_en, stall,
                         src_a_sel, src_b_sel})) begin
            AST_INTERLOCK_NO_BYPASS: assert (mode_fwd || (src_a_sel == 2'b00 && src_b_sel == 2'b00)); // R8
            AST_UNUSED_B_IDLE: assert (dec_use_b || src_b_sel == 2'b00);                              // R3
            AST_UNUSED_A_IDLE: assert (dec_use_a || src_a_sel == 2'b00);                              // R2
            AST_NO_WRITERS_NO_STALL: assert (ex_wr_en || mem_wr_en || !stall);                        // R1
            AST_BYPASS_STALL_LOAD: assert (!(mode_fwd && stall) || (ex_is_load && ex_wr_en));         // R9
            AST_SEL_LEGAL: assert (src_a_sel != 2'b11 && src_b_sel != 2'b11);                          // R10
        end
    end
endmodule

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
    localparam int unsigned REG_AW = 5;
    localparam int unsigned DATA_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              mode_fwd;
    logic [REG_AW-1:0] dec_src_a, dec_src_b, ex_dst, mem_dst;
    logic              dec_use_a, dec_use_b, ex_wr_en, ex_is_load, mem_wr_en;
    logic [DATA_W-1:0] ex_alu_val, mem_wr_val;
    logic [1:0]        src_a_sel, src_b_sel;
    logic [DATA_W-1:0] src_a_val, src_b_val;
    logic              stall;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    hazard_unit #(.REG_AW(REG_AW), .DATA_W(DATA_W)) i_hazard_unit (
        .mode_fwd(mode_fwd), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
        .ex_wr_en(ex_wr_en), .ex_dst(ex_dst), .ex_is_load(ex_is_load), .ex_alu_val(ex_alu_val),
        .mem_wr_en(mem_wr_en), .mem_dst(mem_dst), .mem_wr_val(mem_wr_val),
        .src_a_sel(src_a_sel), .src_a_val(src_a_val),
        .src_b_sel(src_b_sel), .src_b_val(src_b_val), .stall(stall)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // independent operand model; returns select, value, hit, load-block and a requirement tag
    task automatic model_op(input logic use_s, input logic [REG_AW-1:0] s, input bit is_b,
                            output logic [1:0] e_sel, output logic [DATA_W-1:0] e_val,
                            output bit hit, output bit blk, output string tag);
        bit exm, memm, exz, memz;
        exm  = use_s && ex_wr_en  && ex_dst  != 0 && ex_dst  == s;
        memm = use_s && mem_wr_en && mem_dst != 0 && mem_dst == s;
        exz  = ex_wr_en  && ex_dst  == 0 && s == 0;
        memz = mem_wr_en && mem_dst == 0 && s == 0;
        hit = exm || memm;
        blk = exm && ex_is_load;
        e_sel = 2'b00;
        e_val = '0;
        if (mode_fwd) begin
            if (exm && !ex_is_load) begin e_sel = 2'b10; e_val = ex_alu_val; end
            else if (!exm && memm)  begin e_sel = 2'b01; e_val = mem_wr_val; end
        end
        if (!mode_fwd)              tag = "R8";
        else if (blk)               tag = "R7";
        else if (exm && memm)       tag = "R6";
        else if (exm)               tag = "R5";
        else if (memm)              tag = "R4";
        else if (!use_s)            tag = is_b ? "R3" : "R2";
        else if (exz || memz)       tag = "R1";
        else                        tag = "R10";
    endtask

    task automatic apply_and_check();
        logic [1:0] ea, eb;
        logic [DATA_W-1:0] va, vb;
        bit ha, hb, ba, bb, est;
        string ta, tb_, ts;
        #2;
        model_op(dec_use_a, dec_src_a, 1'b0, ea, va, ha, ba, ta);
        model_op(dec_use_b, dec_src_b, 1'b1, eb, vb, hb, bb, tb_);
        est = mode_fwd ? (ba || bb) : (ha || hb);
        ts = !mode_fwd ? "R8" : (est ? "R7" : "R9");
        check(ta,  "src_a_sel", 64'(src_a_sel), 64'(ea));
        check(ta,  "src_a_val", 64'(src_a_val), 64'(va));
        check(tb_, "src_b_sel", 64'(src_b_sel), 64'(eb));
        check(tb_, "src_b_val", 64'(src_b_val), 64'(vb));
        check(ts,  "stall",     64'(stall),     64'(est));
    endtask

    initial begin
        mode_fwd = 0; dec_src_a = 0; dec_src_b = 0; dec_use_a = 0; dec_use_b = 0;
        ex_wr_en = 0; ex_dst = 0; ex_is_load = 0; ex_alu_val = 0;
        mem_wr_en = 0; mem_dst = 0; mem_wr_val = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: nothing selected, no stall (R10)
        @(negedge clk);
        #2;
        check("R10", "idle src_a_sel", 64'(src_a_sel), 64'd0);
        check("R10", "idle src_b_sel", 64'(src_b_sel), 64'd0);
        check("R9",  "idle stall",     64'(stall),     64'd0);

        // near-exhaustive sweep over registers 0..3 and all control bits
        for (int regs = 0; regs < 256; regs++) begin
            for (int ctl = 0; ctl < 64; ctl++) begin
                @(negedge clk);
                dec_src_a  = REG_AW'(regs & 3);
                dec_src_b  = REG_AW'((regs >> 2) & 3);
                ex_dst     = REG_AW'((regs >> 4) & 3);
                mem_dst    = REG_AW'((regs >> 6) & 3);
                dec_use_a  = ctl[0];
                dec_use_b  = ctl[1];
                ex_wr_en   = ctl[2];
                ex_is_load = ctl[3];
                mem_wr_en  = ctl[4];
                mode_fwd   = ctl[5];
                ex_alu_val = 32'hE000_0000 | 32'(regs * 64 + ctl);
                mem_wr_val = 32'h3000_0000 | 32'(regs * 64 + ctl);
                apply_and_check();
            end
        end

        // full-width register numbers with pseudo-random fields
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            {dec_src_a, dec_src_b, ex_dst, mem_dst} = 20'($urandom);
            {dec_use_a, dec_use_b, ex_wr_en, ex_is_load, mem_wr_en, mode_fwd} = 6'($urandom);
            if (k % 3 == 0) ex_dst = dec_src_a;
            if (k % 5 == 0) mem_dst = dec_src_b;
            ex_alu_val = $urandom;
            mem_wr_val = $urandom;
            apply_and_check();
        end
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule